// File: doc/BRIEF.md
# Carry-Conditional Relative Branch Unit

This block owns the program counter of a small processor core and executes one instruction kind on its own: a one-word relative branch that is taken only when the carry flag is set. Every instruction cycle is four clocks long, tracked by a free-running phase counter. An instruction word is offered on a valid/ready intake. A word is taken only on the first phase of a non-idle instruction cycle, and it advances the program counter by one word (2 bytes) as it is taken.

When the word is the carry branch and the carry captured with it is set, the block works out the target during the cycle. It adds twice the sign-extended 8-bit offset to the already advanced program counter, modulo 2^21. It loads the target on the last phase. The next instruction cycle is then left idle, so the word that fetch had already prefetched can be thrown away. The block asks fetch to hold for that whole cycle and sends a single-clock flush at its start. A branch whose carry is clear, or any other word, ends after one instruction cycle with no further change to the program counter.

Back-pressure on the intake: `ins_ready` is high only in phase 0 of a non-idle cycle. The sender holds `ins_valid`, `ins_word` and `carry_in` until a clock edge where both `ins_valid` and `ins_ready` are high. A cycle in which no word is offered does not move the program counter.

Top module: `cbr_pc_unit`

## Requirements
- R1: `phase_o` counts 0,1,2,3 and wraps to 0, advancing by one on every clock edge outside reset. Phase 0 is the decode phase, phase 3 the write-back phase.
- R2: `ins_ready` is high only in phase 0 of an instruction cycle that is not idle. A word is accepted on an edge where `ins_valid` and `ins_ready` are both high. When no word is accepted, the program counter does not move.
- R3: On the accepting edge, `pc_o` becomes its previous value plus 2, modulo 2^21.
- R4: A word whose upper byte is 8'hE2 is the carry branch, and its low byte n is a two's-complement offset from -128 to 127. If `carry_in` was 1 on the accepting edge, then on the phase-3 edge of that cycle `pc_o` becomes (address of the branch word) + 2 + 2n. With n = 5 at address A, the result is A+12.
- R5: A carry branch accepted with `carry_in` 0 leaves `pc_o` at the address plus 2. So does any word whose upper byte is not 8'hE2. In both cases the next word can be accepted 4 clocks after the accepting edge.
- R6: After a taken branch, the next instruction cycle is idle. `hold_o` is high for its 4 clocks, `ins_ready` stays low, `pc_o` stays still, and the next word is accepted 8 clocks after the branch's accepting edge.
- R7: `flush_o` is high for exactly one clock per taken branch: the phase-0 clock of the idle cycle.
- R8: Target arithmetic wraps modulo 2^21, and bit 0 of `pc_o` is always 0.
- R9: While `rst` is high, `pc_o` is 0, `phase_o` is 0, and `hold_o` and `flush_o` are low.
- R10: Changes to `carry_in` after the accepting edge have no effect on whether the branch is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per phase |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Block will take the word on this edge |
| ins_word | input | 16 | Instruction word |
| carry_in | input | 1 | Carry flag, sampled with the word |
| pc_o | output | 21 | Program counter, byte address |
| phase_o | output | 2 | Current phase within the instruction cycle |
| hold_o | output | 1 | Fetch must hold; idle cycle after a taken branch |
| flush_o | output | 1 | Discard the prefetched word (one clock) |

## Verification
The branch is tried with carry set and with carry clear, so the bench can tell a taken branch from a plain step. Offsets are small positive, minus one, the most negative and the most positive; starting from address 0, the extremes wrap both downward and upward across the 2^21 boundary and expose any sign or shift error. Words that differ from the branch encoding by a single bit must behave as plain steps, which shows how exact the decode is. Flipping the carry just after acceptance, offering a word during the idle cycle, and leaving the intake empty separate where carry is sampled, how back-pressure works, and whether an empty slot moves the counter.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  // Instruction-cycle kind: running normally or idle after a taken branch
  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_IDLE = 1'b1
  } cyc_state_e;

  // Roles of the phases inside one instruction cycle
  localparam int PH_DEC = 0;  // decode and intake
  localparam int PH_LIT = 1;  // literal extension
  localparam int PH_ALU = 2;  // target sum
endpackage

// File: rtl/cbr_phase_ctr.sv
module cbr_phase_ctr #(
  parameter int PHASES = 4,
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            first,
  output logic            last
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (last) phase <= '0;
    else           phase <= phase + 1'b1;
  end

  assign first = (phase == '0);
  assign last  = (phase == PH_LAST);
endmodule

// File: rtl/cbr_decode.sv
module cbr_decode #(
  parameter int INS_W = 16,
  parameter int OFS_W = 8,
  parameter logic [INS_W-OFS_W-1:0] OPC = 8'hE2
) (
  input  logic [INS_W-1:0] word,
  output logic             match,
  output logic [OFS_W-1:0] lit
);
  // Opcode field sits above the offset field
  assign match = (word[INS_W-1:OFS_W] == OPC);
  assign lit   = word[OFS_W-1:0];
endmodule

// File: rtl/cbr_target.sv
module cbr_target
  import cbr_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int OFS_W  = 8,
  parameter int PHASES = 4,
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  phase,
  input  logic [OFS_W-1:0] lit_q,
  input  logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  tgt
);
  localparam int EXT_W = PC_W - OFS_W - 1;

  logic [PC_W-1:0] ofs_q;

  // Literal phase: sign-extend and double the word offset
  always_ff @(posedge clk) begin
    if (rst)
      ofs_q <= '0;
    else if (phase == PH_W'(PH_LIT))
      ofs_q <= {{EXT_W{lit_q[OFS_W-1]}}, lit_q, 1'b0};
  end

  // Sum phase: pc has already stepped past the branch word
  always_ff @(posedge clk) begin
    if (rst)
      tgt <= '0;
    else if (phase == PH_W'(PH_ALU))
      tgt <= pc + ofs_q;
  end
endmodule

// File: rtl/cbr_seq.sv
module cbr_seq
  import cbr_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int OFS_W = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first,
  input  logic             last,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic             match,
  input  logic [OFS_W-1:0] lit_in,
  input  logic             carry_in,
  input  logic [PC_W-1:0]  tgt,
  output logic [OFS_W-1:0] lit_q,
  output logic [PC_W-1:0]  pc,
  output logic             hold,
  output logic             flush
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(2);

  cyc_state_e state;
  logic       pend;
  logic       bc_q;
  logic       cy_q;
  logic       accept;

  assign ins_ready = (state == ST_RUN) && first;
  assign accept    = ins_valid && ins_ready;
  assign hold      = (state == ST_IDLE);
  assign flush     = hold && first;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RUN;
      pend  <= 1'b0;
      bc_q  <= 1'b0;
      cy_q  <= 1'b0;
      lit_q <= '0;
      pc    <= RESET_PC;
    end else begin
      if (accept) begin
        pc    <= pc + PC_STEP;
        pend  <= 1'b1;
        bc_q  <= match;
        cy_q  <= carry_in;
        lit_q <= lit_in;
      end
      if (last) begin
        if (state == ST_IDLE) begin
          state <= ST_RUN;
        end else if (pend) begin
          pend <= 1'b0;
          if (bc_q && cy_q) begin
            pc    <= tgt;
            state <= ST_IDLE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cbr_pc_unit.sv
module cbr_pc_unit #(
  parameter int PC_W   = 21,
  parameter int INS_W  = 16,
  parameter int OFS_W  = 8,
  parameter int PHASES = 4,
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [INS_W-1:0] ins_word,
  input  logic             carry_in,
  output logic [PC_W-1:0]  pc_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             hold_o,
  output logic             flush_o
);
  logic             ph_first;
  logic             ph_last;
  logic             dec_match;
  logic [OFS_W-1:0] dec_lit;
  logic [OFS_W-1:0] lit_q;
  logic [PC_W-1:0]  tgt;

  cbr_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (phase_o),
    .first (ph_first),
    .last  (ph_last)
  );

  cbr_decode #(.INS_W(INS_W), .OFS_W(OFS_W)) u_dec (
    .word  (ins_word),
    .match (dec_match),
    .lit   (dec_lit)
  );

  cbr_target #(.PC_W(PC_W), .OFS_W(OFS_W), .PHASES(PHASES)) u_tgt (
    .clk   (clk),
    .rst   (rst),
    .phase (phase_o),
    .lit_q (lit_q),
    .pc    (pc_o),
    .tgt   (tgt)
  );

  cbr_seq #(.PC_W(PC_W), .OFS_W(OFS_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .first     (ph_first),
    .last      (ph_last),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .match     (dec_match),
    .lit_in    (dec_lit),
    .carry_in  (carry_in),
    .tgt       (tgt),
    .lit_q     (lit_q),
    .pc        (pc_o),
    .hold      (hold_o),
    .flush     (flush_o)
  );
endmodule

// File: rtl/cbr_pc_unit_chk.sv
module cbr_pc_unit_chk #(
  parameter int PC_W   = 21,
  parameter int PHASES = 4,
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            ins_valid,
  input logic            ins_ready,
  input logic [PC_W-1:0] pc_o,
  input logic [PH_W-1:0] phase_o,
  input logic            hold_o,
  input logic            flush_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase_o == (($past(phase_o) == PH_LAST) ? '0 : $past(phase_o) + 1'b1));

  p_ready_q1_r2: assert property (@(posedge clk) disable iff (rst)
    ins_ready |-> (phase_o == '0) && !hold_o);

  p_accept_step_r3: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_ready) |=> pc_o == $past(pc_o) + PC_W'(2));

  p_hold_pc_still_r6: assert property (@(posedge clk) disable iff (rst)
    hold_o |=> $stable(pc_o));

  p_flush_in_hold_r7: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> hold_o && (phase_o == '0));

  p_flush_single_r7: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o);

  p_pc_even_r8: assert property (@(posedge clk) disable iff (rst)
    pc_o[0] == 1'b0);
endmodule

bind cbr_pc_unit cbr_pc_unit_chk #(.PC_W(PC_W), .PHASES(PHASES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .pc_o      (pc_o),
  .phase_o   (phase_o),
  .hold_o    (hold_o),
  .flush_o   (flush_o)
);

// File: tb/cbr_pc_unit_tb_top.sv
`timescale 1ns/1ps
module cbr_pc_unit_tb_top;
  localparam int MASK = 32'h1FFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [15:0] ins_word = '0;
  logic        carry_in = 1'b0;
  logic [20:0] pc_o;
  logic [1:0]  phase_o;
  logic        hold_o;
  logic        flush_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cbr_pc_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .ins_word  (ins_word),
    .carry_in  (carry_in),
    .pc_o      (pc_o),
    .phase_o   (phase_o),
    .hold_o    (hold_o),
    .flush_o   (flush_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference, updated on each rising edge
  int m_ph = 0, m_pc = 0, m_n = 0;
  bit m_idle = 0, m_pend = 0, m_bc = 0, m_cy = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_pc = 0; m_idle = 0; m_pend = 0;
    end else begin
      if (!m_idle && m_ph == 0 && ins_valid) begin
        m_pc   = (m_pc + 2) & MASK;
        m_pend = 1;
        m_bc   = (ins_word[15:8] == 8'hE2);
        m_cy   = carry_in;
        m_n    = int'($signed(ins_word[7:0]));
      end else if (m_ph == 3) begin
        if (m_idle) m_idle = 0;
        else if (m_pend) begin
          m_pend = 0;
          if (m_bc && m_cy) begin
            m_pc   = (m_pc + 2 * m_n) & MASK;
            m_idle = 1;
          end
        end
      end
      m_ph = (m_ph + 1) % 4;
    end
  end

  // Per-clock comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(phase_o) == m_ph, "R1", "phase", int'(phase_o), m_ph);
      chk(ins_ready == (!m_idle && m_ph == 0), "R2", "ready", int'(ins_ready),
          int'(!m_idle && m_ph == 0));
      chk(int'(pc_o) == m_pc, "R4", "pc", int'(pc_o), m_pc);
      chk(hold_o == m_idle, "R6", "hold", int'(hold_o), int'(m_idle));
      chk(flush_o == (m_idle && m_ph == 0), "R7", "flush", int'(flush_o),
          int'(m_idle && m_ph == 0));
    end
  end

  // Offer a word, change carry right after it is taken, count clocks to next ready
  task automatic send(input logic [15:0] w, input logic c, input logic c_after,
                      output int cyc);
    @(negedge clk);
    ins_valid = 1'b1; ins_word = w; carry_in = c;
    while (!ins_ready) @(negedge clk);
    @(negedge clk);
    ins_valid = 1'b0; carry_in = c_after;
    cyc = 1;
    while (!ins_ready) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [20:0] pc_snap;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(pc_o == '0, "R9", "pc in reset", int'(pc_o), 0);
    chk(phase_o == '0, "R9", "phase in reset", int'(phase_o), 0);
    chk(!hold_o && !flush_o, "R9", "hold/flush in reset", int'({hold_o, flush_o}), 0);
    rst = 1'b0;

    // R8: most negative offset from address 0 wraps downward
    send(16'hE280, 1'b1, 1'b1, cyc);
    chk(pc_o == 21'h1FFF02, "R8", "wrap down", int'(pc_o), 32'h1FFF02);
    chk(cyc == 8, "R6", "taken cycle length", cyc, 8);
    // R8: most positive offset wraps upward
    send(16'hE27F, 1'b1, 1'b1, cyc);
    chk(pc_o == 21'h000002, "R8", "wrap up", int'(pc_o), 2);

    // R3: plain words step by one word
    send(16'h0000, 1'b1, 1'b1, cyc);
    send(16'h0000, 1'b0, 1'b0, cyc);
    chk(pc_o == 21'd6, "R3", "step", int'(pc_o), 6);
    chk(cyc == 4, "R5", "plain cycle length", cyc, 4);

    // R4: offset 5 at address 6 with carry set lands at 18
    send(16'hE205, 1'b1, 1'b1, cyc);
    chk(pc_o == 21'd18, "R4", "offset 5 taken", int'(pc_o), 18);
    // R5: same branch with carry clear
    send(16'hE205, 1'b0, 1'b0, cyc);
    chk(pc_o == 21'd20, "R5", "offset 5 not taken", int'(pc_o), 20);
    chk(cyc == 4, "R5", "not-taken cycle length", cyc, 4);
    // R4: offset -1 branches onto itself
    send(16'hE2FF, 1'b1, 1'b1, cyc);
    chk(pc_o == 21'd20, "R4", "offset -1", int'(pc_o), 20);

    // R5: near-miss opcodes are plain steps even with carry set
    send(16'hE305, 1'b1, 1'b1, cyc);
    send(16'hE605, 1'b1, 1'b1, cyc);
    send(16'h6205, 1'b1, 1'b1, cyc);
    send(16'hA205, 1'b1, 1'b1, cyc);
    chk(pc_o == 21'd28, "R5", "near-miss opcodes", int'(pc_o), 28);
    chk(cyc == 4, "R5", "near-miss cycle length", cyc, 4);

    // R10: carry changed after acceptance is ignored
    send(16'hE210, 1'b0, 1'b1, cyc);
    chk(pc_o == 21'd30, "R10", "late carry rise", int'(pc_o), 30);
    send(16'hE210, 1'b1, 1'b0, cyc);
    chk(pc_o == 21'd64, "R10", "late carry fall", int'(pc_o), 64);

    // R6: word offered during the idle cycle waits for the next phase 0
    @(negedge clk);
    ins_valid = 1'b1; ins_word = 16'hE202; carry_in = 1'b1;
    while (!ins_ready) @(negedge clk);
    @(negedge clk);
    ins_word = 16'h0000; carry_in = 1'b0;
    cyc = 1;
    while (!ins_ready) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 8, "R6", "held word wait", cyc, 8);
    chk(pc_o == 21'd70, "R6", "pc before held word", int'(pc_o), 70);
    @(negedge clk);
    ins_valid = 1'b0;
    chk(pc_o == 21'd72, "R2", "held word taken", int'(pc_o), 72);

    // R2: empty intake leaves the counter alone
    pc_snap = pc_o;
    repeat (12) @(negedge clk);
    chk(pc_o == pc_snap, "R2", "empty intake", int'(pc_o), int'(pc_snap));

    // R4: most positive offset without wrap
    send(16'hE27F, 1'b1, 1'b1, cyc);
    chk(pc_o == 21'd328, "R4", "offset 127", int'(pc_o), 328);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule